// File: doc/BRIEF.md
# Solenoid Column Pulse-Height Driver

This block sequences a 16 x 16 array of solenoid-driven pins, one column at a time. A command port, fed by an upstream decoder, stores a 3-bit height code for any pin, advances the column pointer, fires the selected column, or clears the selected column. When a column fires, every row with a nonzero code is energised in the same cycle. Each row then stays energised for a time proportional to its code, so the pulse length sets how far that pin rises.

A clear command drives all 16 rows of the selected column for a fixed interval, with a polarity output raised so the external driver reverses the coil current. While any pulse is running, a busy output is high. Any command that arrives in that window is dropped, and a sticky overrun flag records the event. The coil drivers, their supply switching and all image handling sit outside this block.

Top module: `pinpulse_ctrl`

## Requirements
- R1: After reset, row_en, pwm_gate, drive_rev, busy and overrun are 0, col_sel is 0, and every stored height code is 0.
- R2: A command with cmd_op = 2'b00 (load), accepted while not busy, stores cmd_height[2:0] as the code of the pin at column cmd_col, row cmd_row.
- R3: A command with cmd_op = 2'b01 (fire), accepted while not busy, raises row_en bit r in the next cycle when the code of row r in column col_sel is nonzero. That bit then stays high for exactly code x T_UNIT cycles, and drive_rev stays 0.
- R4: After a fire, busy is high from the cycle after acceptance for exactly max(code) x T_UNIT cycles. If the selected column holds only zero codes, the fire has no effect: busy and row_en stay 0.
- R5: pwm_gate is high exactly when at least one bit of row_en is high.
- R6: A command with cmd_op = 2'b10 (next), accepted while not busy, increments col_sel by one in the next cycle. Column 15 wraps to column 0.
- R7: A command with cmd_op = 2'b11 (clear), accepted while not busy, drives all 16 row_en bits and drive_rev high from the next cycle for exactly T_RESET cycles. busy is high for the same interval.
- R8: A command presented while busy is high is ignored: col_sel, the stored codes and the running pulse are unchanged. overrun goes high and stays high until reset.
- R9: Loading codes into a column other than col_sel does not change the pulses that a fire produces on col_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 00 load, 01 fire, 10 next column, 11 clear column |
| cmd_col | input | 4 | Column addressed by a load |
| cmd_row | input | 4 | Row addressed by a load |
| cmd_height | input | 3 | Height code written by a load |
| row_en | output | 16 | Per-row coil enable for the selected column |
| col_sel | output | 4 | Selected column |
| pwm_gate | output | 1 | High while any coil of the column is energised |
| drive_rev | output | 1 | Reverse-polarity drive during a clear pulse |
| busy | output | 1 | Pulse sequence in progress |
| overrun | output | 1 | Sticky flag: a command arrived while busy |

## Verification
A corrupted pulse counter or latched length shows up at once as a row_en bit that drops one cycle early or late against its code, or as busy ending while a row is still high. A bad code store appears on the next fire of that column as a wrong row pattern, and a bad column pointer appears in the same cycle on col_sel. The bench therefore compares row_en, pwm_gate, busy and drive_rev on every cycle of every pulse, so any timing slip is caught on the first cycle where it occurs.

// File: rtl/pinpulse_pkg.sv
package pinpulse_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_FIRE  = 2'b01,
    OP_NEXT  = 2'b10,
    OP_CLEAR = 2'b11
  } pin_op_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pinpulse_store.sv
module pinpulse_store #(
  parameter int N_ROWS = 16,
  parameter int N_COLS = 16,
  parameter int HW     = 3,
  localparam int CAW   = $clog2(N_COLS),
  localparam int RAW   = $clog2(N_ROWS)
) (
  input  logic                       clk,
  input  logic                       rst_ns,
  input  logic                       wr_en,
  input  logic [CAW-1:0]             wr_col,
  input  logic [RAW-1:0]             wr_row,
  input  logic [HW-1:0]              wr_h,
  input  logic [CAW-1:0]             rd_col,
  output logic [N_ROWS-1:0][HW-1:0]  rd_h
);

  logic [HW-1:0] mem_q [N_COLS][N_ROWS];

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      logic cell_we;
      assign cell_we = wr_en && (wr_col == CAW'(c)) && (wr_row == RAW'(r));
      always_ff @(posedge clk or negedge rst_ns) begin
        if (!rst_ns) begin
          mem_q[c][r] <= '0;
        end else if (cell_we) begin
          mem_q[c][r] <= wr_h;
        end
      end
    end
  end

  always_comb begin
    for (int r = 0; r < N_ROWS; r++) begin
      rd_h[r] = mem_q[rd_col][r];
    end
  end

  // R2
  store_write_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    wr_en |=> mem_q[$past(wr_col)][$past(wr_row)] == $past(wr_h));

endmodule

// File: rtl/pinpulse_timer.sv
module pinpulse_timer #(
  parameter int CW      = 5,
  parameter int T_RESET = 20
) (
  input  logic          clk,
  input  logic          rst_ns,
  input  logic          start_fire,
  input  logic          start_clear,
  input  logic [CW-1:0] fire_len,
  output logic          active,
  output logic          rev,
  output logic [CW-1:0] cnt
);

  logic          active_q, active_d;
  logic          rev_q, rev_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len_q, len_d;

  always_comb begin
    active_d = active_q;
    rev_d    = rev_q;
    cnt_d    = cnt_q;
    len_d    = len_q;
    if (active_q) begin
      if (cnt_q == len_q - CW'(1)) begin
        active_d = 1'b0;
        rev_d    = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end else if (start_fire && (fire_len != '0)) begin
      active_d = 1'b1;
      rev_d    = 1'b0;
      cnt_d    = '0;
      len_d    = fire_len;
    end else if (start_clear) begin
      active_d = 1'b1;
      rev_d    = 1'b1;
      cnt_d    = '0;
      len_d    = CW'(T_RESET);
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      active_q <= 1'b0;
      rev_q    <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
    end else begin
      active_q <= active_d;
      rev_q    <= rev_d;
      cnt_q    <= cnt_d;
      len_q    <= len_d;
    end
  end

  assign active = active_q;
  assign rev    = rev_q;
  assign cnt    = cnt_q;

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (active_q && (cnt_q != len_q - CW'(1))) |=> active_q);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    active_q |-> (cnt_q < len_q));

  // R7
  rev_only_active_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    rev_q |-> active_q);

endmodule

// File: rtl/pinpulse_rowgen.sv
module pinpulse_rowgen #(
  parameter int N_ROWS  = 16,
  parameter int HW      = 3,
  parameter int CW      = 5,
  parameter int T_UNIT  = 4,
  parameter int T_RESET = 20
) (
  input  logic                       clk,
  input  logic                       rst_ns,
  input  logic                       active,
  input  logic                       rev,
  input  logic [CW-1:0]              cnt,
  input  logic [N_ROWS-1:0][HW-1:0]  heights,
  output logic [N_ROWS-1:0]          row_en
);

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    logic [CW-1:0] limit;
    always_comb begin
      if (rev) begin
        limit = CW'(T_RESET);
      end else begin
        limit = CW'(heights[r]) * CW'(T_UNIT);
      end
    end
    assign row_en[r] = active && (cnt < limit);
  end

  // R3
  row_mono_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (active && $past(active)) |-> ((row_en & ~$past(row_en)) == '0));

  // R7
  rev_full_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    rev |-> (row_en == {N_ROWS{1'b1}}));

endmodule

// File: rtl/pinpulse_ctrl.sv
module pinpulse_ctrl
  import pinpulse_pkg::*;
#(
  parameter int N_ROWS  = 16,
  parameter int N_COLS  = 16,
  parameter int HW      = 3,
  parameter int T_UNIT  = 4,
  parameter int T_RESET = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [1:0]                  cmd_op,
  input  logic [$clog2(N_COLS)-1:0]   cmd_col,
  input  logic [$clog2(N_ROWS)-1:0]   cmd_row,
  input  logic [HW-1:0]               cmd_height,
  output logic [N_ROWS-1:0]           row_en,
  output logic [$clog2(N_COLS)-1:0]   col_sel,
  output logic                        pwm_gate,
  output logic                        drive_rev,
  output logic                        busy,
  output logic                        overrun
);

  localparam int CAW     = $clog2(N_COLS);
  localparam int RAW     = $clog2(N_ROWS);
  localparam int HMAX    = (1 << HW) - 1;
  localparam int LEN_MAX = max_int(HMAX * T_UNIT, T_RESET);
  localparam int CW      = $clog2(LEN_MAX + 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ns = rst_sync_q[1];

  // command decode
  logic    active, rev;
  logic    accept;
  pin_op_e op;
  logic    do_load, do_fire, do_next, do_clear;

  assign op       = pin_op_e'(cmd_op);
  assign accept   = cmd_valid && !active;
  assign do_load  = accept && (op == OP_LOAD);
  assign do_fire  = accept && (op == OP_FIRE);
  assign do_next  = accept && (op == OP_NEXT);
  assign do_clear = accept && (op == OP_CLEAR);

  // column pointer and overrun flag
  logic [CAW-1:0] col_q, col_d;
  logic           ovr_q, ovr_d;

  always_comb begin
    col_d = col_q;
    if (do_next) begin
      col_d = (col_q == CAW'(N_COLS - 1)) ? '0 : col_q + CAW'(1);
    end
    ovr_d = ovr_q | (cmd_valid && active);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      col_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      col_q <= col_d;
      ovr_q <= ovr_d;
    end
  end

  // height store
  logic [N_ROWS-1:0][HW-1:0] col_h;

  pinpulse_store #(
    .N_ROWS (N_ROWS),
    .N_COLS (N_COLS),
    .HW     (HW)
  ) u_store (
    .clk    (clk),
    .rst_ns (rst_ns),
    .wr_en  (do_load),
    .wr_col (cmd_col),
    .wr_row (cmd_row),
    .wr_h   (cmd_height),
    .rd_col (col_q),
    .rd_h   (col_h)
  );

  // longest pulse of the selected column
  logic [HW-1:0] h_max;
  logic [CW-1:0] fire_len;
  always_comb begin
    h_max = '0;
    for (int r = 0; r < N_ROWS; r++) begin
      if (col_h[r] > h_max) h_max = col_h[r];
    end
    fire_len = CW'(h_max) * CW'(T_UNIT);
  end

  logic [CW-1:0] cnt;

  pinpulse_timer #(
    .CW      (CW),
    .T_RESET (T_RESET)
  ) u_timer (
    .clk         (clk),
    .rst_ns      (rst_ns),
    .start_fire  (do_fire),
    .start_clear (do_clear),
    .fire_len    (fire_len),
    .active      (active),
    .rev         (rev),
    .cnt         (cnt)
  );

  pinpulse_rowgen #(
    .N_ROWS  (N_ROWS),
    .HW      (HW),
    .CW      (CW),
    .T_UNIT  (T_UNIT),
    .T_RESET (T_RESET)
  ) u_rowgen (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .active  (active),
    .rev     (rev),
    .cnt     (cnt),
    .heights (col_h),
    .row_en  (row_en)
  );

  assign col_sel   = col_q;
  assign pwm_gate  = |row_en;
  assign drive_rev = rev;
  assign busy      = active;
  assign overrun   = ovr_q;

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $past(ovr_q) |-> ovr_q);

  // R8
  busy_col_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    active |=> (col_q == $past(col_q)));

  // R6
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !$stable(col_q) |-> ((col_q == $past(col_q) + CAW'(1)) ||
                         (col_q == '0 && $past(col_q) == CAW'(N_COLS - 1))));

  // R5
  gate_busy_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    pwm_gate |-> busy);

endmodule

// File: tb/pinpulse_ctrl_tb.sv
module pinpulse_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int T_UNIT     = 4;
  localparam int T_RESET    = 20;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [3:0]  cmd_col;
  logic [3:0]  cmd_row;
  logic [2:0]  cmd_height;
  logic [15:0] row_en;
  logic [3:0]  col_sel;
  logic        pwm_gate;
  logic        drive_rev;
  logic        busy;
  logic        overrun;

  int n_checks = 0;
  int n_fails  = 0;
  logic [2:0] exp_h [16][16];

  pinpulse_ctrl #(
    .N_ROWS  (16),
    .N_COLS  (16),
    .HW      (3),
    .T_UNIT  (T_UNIT),
    .T_RESET (T_RESET)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_col    (cmd_col),
    .cmd_row    (cmd_row),
    .cmd_height (cmd_height),
    .row_en     (row_en),
    .col_sel    (col_sel),
    .pwm_gate   (pwm_gate),
    .drive_rev  (drive_rev),
    .busy       (busy),
    .overrun    (overrun)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one command for one cycle; returns at the negedge after acceptance
  task automatic send(input logic [1:0] op, input logic [3:0] c,
                      input logic [3:0] r, input logic [2:0] h);
    cmd_valid  = 1'b1;
    cmd_op     = op;
    cmd_col    = c;
    cmd_row    = r;
    cmd_height = h;
    @(negedge clk);
    cmd_valid  = 1'b0;
  endtask

  task automatic load(input logic [3:0] c, input logic [3:0] r, input logic [2:0] h);
    send(2'b00, c, r, h);
    exp_h[c][r] = h;
  endtask

  // fire the column col_sel and compare every cycle of the pulse
  task automatic fire_and_check(input logic [3:0] c, input string req);
    int len;
    int bad;
    logic [15:0] first_act, first_exp;
    len = 0;
    for (int r = 0; r < 16; r++)
      if (int'(exp_h[c][r]) * T_UNIT > len) len = int'(exp_h[c][r]) * T_UNIT;
    send(2'b01, 4'd0, 4'd0, 3'd0);
    bad = 0;
    first_act = '0;
    first_exp = '0;
    for (int j = 0; j <= len; j++) begin
      logic [15:0] er;
      for (int r = 0; r < 16; r++) er[r] = (j < int'(exp_h[c][r]) * T_UNIT);
      if (row_en !== er || busy !== (j < len) || pwm_gate !== (|er) || drive_rev !== 1'b0) begin
        if (bad == 0) begin
          first_act = row_en;
          first_exp = er;
        end
        bad++;
      end
      if (j < len) @(negedge clk);
    end
    check(bad == 0, req, {busy, pwm_gate, drive_rev, 13'd0, first_act},
          {1'b0, 1'b0, 1'b0, 13'd0, first_exp});
  endtask

  task automatic t_reset_state();
    check(row_en == '0 && pwm_gate == 1'b0 && drive_rev == 1'b0, "R1 outputs idle",
          {row_en, 13'd0, pwm_gate, drive_rev, 1'b0}, 32'd0);
    check(busy == 1'b0 && overrun == 1'b0 && col_sel == 4'd0, "R1 status clear",
          {busy, overrun, col_sel}, 32'd0);
  endtask

  task automatic t_zero_fire();
    // R1 codes zero, R4 all-zero fire is a no-op
    send(2'b01, 4'd0, 4'd0, 3'd0);
    check(busy == 1'b0 && row_en == '0, "R4 zero column fire",
          {busy, row_en}, 32'd0);
    @(negedge clk);
    check(busy == 1'b0 && overrun == 1'b0, "R1 R4 no busy after zero fire",
          {busy, overrun}, 32'd0);
  endtask

  task automatic t_pattern();
    // R2 R3 R4 R5: codes 0..7 twice over in column 0
    for (int r = 0; r < 16; r++) load(4'd0, 4'(r), 3'(r % 8));
    fire_and_check(4'd0, "R3 mixed heights column 0");
    @(negedge clk);
    for (int r = 0; r < 16; r++) load(4'd0, 4'(r), 3'((r * 3 + 1) % 4));
    fire_and_check(4'd0, "R2 R5 reloaded heights column 0");
  endtask

  task automatic t_single_max();
    // R3 R4: one row at maximum code
    for (int r = 0; r < 16; r++) load(4'd0, 4'(r), 3'd0);
    load(4'd0, 4'd9, 3'd7);
    fire_and_check(4'd0, "R4 single row code 7");
  endtask

  task automatic t_next_wrap();
    // R6: 16 increments visit every column and wrap to 0
    for (int k = 1; k <= 16; k++) begin
      send(2'b10, 4'd0, 4'd0, 3'd0);
      check(col_sel == 4'(k % 16), "R6 column increment", col_sel, k % 16);
    end
  endtask

  task automatic t_other_column();
    // R9: load column 6, fire column 5
    send(2'b10, 4'd0, 4'd0, 3'd0);
    send(2'b10, 4'd0, 4'd0, 3'd0);
    send(2'b10, 4'd0, 4'd0, 3'd0);
    send(2'b10, 4'd0, 4'd0, 3'd0);
    send(2'b10, 4'd0, 4'd0, 3'd0);
    check(col_sel == 4'd5, "R6 column five", col_sel, 5);
    for (int r = 0; r < 16; r++) load(4'd5, 4'(r), 3'((r % 2) * 2));
    for (int r = 0; r < 16; r++) load(4'd6, 4'(r), 3'd7);
    fire_and_check(4'd5, "R9 other column load ignored");
  endtask

  task automatic t_clear();
    int bad;
    // R7: clear column drives all rows reversed
    send(2'b11, 4'd0, 4'd0, 3'd0);
    bad = 0;
    for (int j = 0; j <= T_RESET; j++) begin
      logic on;
      on = (j < T_RESET);
      if (row_en !== {16{on}} || drive_rev !== on || busy !== on || pwm_gate !== on) bad++;
      if (j < T_RESET) @(negedge clk);
    end
    check(bad == 0, "R7 clear pulse", bad, 0);
  endtask

  task automatic t_overrun();
    logic [3:0] c0;
    // R8: commands during a pulse are dropped and flagged
    c0 = col_sel;
    check(overrun == 1'b0, "R8 overrun clear before", overrun, 0);
    send(2'b01, 4'd0, 4'd0, 3'd0);
    send(2'b10, 4'd0, 4'd0, 3'd0);
    check(col_sel == c0 && overrun == 1'b1, "R8 next dropped while busy",
          {overrun, col_sel}, {1'b1, c0});
    send(2'b00, c0, 4'd0, 3'd3);
    send(2'b11, 4'd0, 4'd0, 3'd0);
    check(drive_rev == 1'b0, "R8 clear dropped while busy", drive_rev, 0);
    while (busy) @(negedge clk);
    @(negedge clk);
    check(overrun == 1'b1, "R8 overrun sticky", overrun, 1);
    fire_and_check(c0, "R8 load dropped while busy");
  endtask

  initial begin
    rst_n      = 1'b0;
    cmd_valid  = 1'b0;
    cmd_op     = 2'b00;
    cmd_col    = 4'd0;
    cmd_row    = 4'd0;
    cmd_height = 3'd0;
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < 16; r++) exp_h[c][r] = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_zero_fire();
    t_pattern();
    t_single_max();
    t_next_wrap();
    t_other_column();
    t_clear();
    t_overrun();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule